// File: doc/BRIEF.md
# Comma Word Aligner

The aligner sits after a 10-bit deserialiser whose parallel words fall on arbitrary bit positions of the line code. It joins the previous valid word and the current valid word into a 20-bit window. It scans every one of the ten possible bit offsets for either disparity form of the K28.5 comma. It then cuts each output word from the window at the chosen offset, so every emitted word begins on a symbol boundary.

The controller has two states. In HUNT it accepts the first comma it sees, switches to LOCK and raises the aligned status. In LOCK the offset is frozen while `realign_en` is low. While `realign_en` is high, a comma at a new offset retrains the offset and the block stays in LOCK. A one-cycle `rehunt` pulse returns the block from LOCK to HUNT and drops the aligned status. The output is always two clock cycles behind the input, whatever the offset.

Named transitions:
- HUNT→LOCK on a comma found.
- LOCK→LOCK with a new offset (retrain) when `realign_en` is high and a comma lies at another offset.
- LOCK→HUNT on `rehunt`.
- Any state→HUNT on reset.

Top module: `word_aligner`

## Requirements
- R1: While reset is held, `out_word`, `out_valid`, `comma_det` and `aligned` are all zero.
- R2: `out_valid` follows `in_valid` by exactly two clock cycles.
- R3: Bit 9 of a word is received first. The window is {previous valid word, current valid word}, and offset k selects window bits [19-k:10-k]. All ten offsets are searched for 0011111010 and 1100000101. `comma_det` is high exactly when the emitted word equals one of these two codes.
- R4: Before any comma has been found since reset, the offset is 0, so the output word is the previous valid input word.
- R5: In HUNT, the first window holding a comma sets the offset for that same window. The comma word is emitted with `comma_det`, and `aligned` rises in the same cycle.
- R6: In LOCK with `realign_en` low, the offset is held. A comma at another offset is emitted cut at the old offset, without `comma_det`.
- R7: In LOCK with `realign_en` high, a comma at a new offset replaces the offset, starting with that window.
- R8: Once set, `aligned` stays high until reset or `rehunt`.
- R9: A `rehunt` pulse clears `aligned` at the next edge and returns the block to HUNT. The old offset is kept until the next comma.
- R10: Cycles with `in_valid` low leave the window unchanged, so words separated by gaps are joined as if they had arrived back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 10 | Unaligned word from the deserialiser, bit 9 first on the line |
| in_valid | input | 1 | `in_word` carries a new word |
| realign_en | input | 1 | Allows a comma at a new offset to retrain the offset while locked |
| rehunt | input | 1 | One-cycle request to drop alignment and search again |
| out_word | output | 10 | Word cut on the symbol boundary |
| out_valid | output | 1 | `out_word` is new this cycle |
| comma_det | output | 1 | The emitted word is a comma |
| aligned | output | 1 | A boundary has been found and is in use |

## Verification
The assertions assume that `realign_en` and `rehunt` change only while no word is inside the two-stage pipeline. With that assumption, the latency, lock and hold rules can be stated against the port timing alone. The stimulus honours it: control changes are made only after at least three idle cycles.

The bench builds its words from a continuous bit stream. The padding bits placed before each comma set its offset, and the data symbols are chosen so that no run of five equal bits, and therefore no false comma, can appear across a boundary.

// File: rtl/wal_pkg.sv
package wal_pkg;

    localparam int SYM_W = 10;

    // both running-disparity forms of K28.5, bit 9 first on the line
    localparam logic [SYM_W-1:0] COMMA_NEG = 10'b0011111010;
    localparam logic [SYM_W-1:0] COMMA_POS = 10'b1100000101;

    typedef enum logic {
        ST_HUNT,
        ST_LOCK
    } wal_state_e;

endpackage

// File: rtl/comma_scan.sv
module comma_scan #(
    parameter int               W     = wal_pkg::SYM_W,
    parameter logic [W-1:0]     K_NEG = wal_pkg::COMMA_NEG,
    parameter logic [W-1:0]     K_POS = wal_pkg::COMMA_POS,
    localparam int              OW    = $clog2(W)
) (
    input  logic [2*W-1:0] win,
    output logic           hit_any,
    output logic [OW-1:0]  hit_off
);

    logic [W-1:0] hits;

    for (genvar k = 0; k < W; k++) begin : g_off
        assign hits[k] = (win[2*W-1-k -: W] == K_NEG) ||
                         (win[2*W-1-k -: W] == K_POS);
    end

    assign hit_any = |hits;

    // lowest offset takes priority
    always_comb begin
        hit_off = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hits[k]) begin
                hit_off = OW'(k);
            end
        end
    end

endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int  W  = wal_pkg::SYM_W,
    localparam int OW = $clog2(W)
) (
    input  logic [2*W-1:0] win,
    input  logic [OW-1:0]  sel,
    output logic [W-1:0]   word
);

    logic [W-1:0] cand [W];

    for (genvar k = 0; k < W; k++) begin : g_cand
        assign cand[k] = win[2*W-1-k -: W];
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < W; k++) begin
            if (sel == OW'(k)) begin
                word = cand[k];
            end
        end
    end

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl #(
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          hit_any,
    input  logic [OW-1:0] hit_off,
    input  logic          realign_en,
    input  logic          rehunt,
    output logic [OW-1:0] off_use,
    output logic          aligned
);

    import wal_pkg::*;

    wal_state_e    state_q, state_d;
    logic [OW-1:0] off_q;
    logic          take;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (!rehunt && step && hit_any) state_d = ST_LOCK;
            ST_LOCK: if (rehunt)                     state_d = ST_HUNT;
        endcase
    end

    // state and offset registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            off_q   <= '0;
        end else begin
            state_q <= state_d;
            off_q   <= off_use;
        end
    end

    // outputs
    always_comb begin
        take    = step && hit_any && !rehunt &&
                  ((state_q == ST_HUNT) || realign_en);
        off_use = take ? hit_off : off_q;
        aligned = (state_q == ST_LOCK);
    end

    a_r6_hold_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !realign_en) |=> (off_q == $past(off_q)));

    a_r8_sticky_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aligned) |-> $past(rehunt));

endmodule

// File: rtl/word_aligner.sv
module word_aligner #(
    parameter int  W  = wal_pkg::SYM_W,
    localparam int OW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_word,
    input  logic         in_valid,
    input  logic         realign_en,
    input  logic         rehunt,
    output logic [W-1:0] out_word,
    output logic         out_valid,
    output logic         comma_det,
    output logic         aligned
);

    import wal_pkg::*;

    logic [W-1:0]   hold_q;
    logic [2*W-1:0] win_q;
    logic           v1_q;
    logic           hit_any;
    logic [OW-1:0]  hit_off;
    logic [OW-1:0]  off_use;
    logic [W-1:0]   cut_word;
    logic [1:0]     age_q;

    // stage 1: build the two-word window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            win_q  <= '0;
            v1_q   <= 1'b0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                hold_q <= in_word;
                win_q  <= {hold_q, in_word};
            end
        end
    end

    comma_scan #(.W(W)) u_scan (
        .win     (win_q),
        .hit_any (hit_any),
        .hit_off (hit_off)
    );

    align_ctrl #(.OW(OW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (v1_q),
        .hit_any    (hit_any),
        .hit_off    (hit_off),
        .realign_en (realign_en),
        .rehunt     (rehunt),
        .off_use    (off_use),
        .aligned    (aligned)
    );

    word_shifter #(.W(W)) u_shift (
        .win  (win_q),
        .sel  (off_use),
        .word (cut_word)
    );

    // stage 2: registered aligned word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
            comma_det <= 1'b0;
        end else begin
            out_valid <= v1_q;
            comma_det <= v1_q && ((cut_word == COMMA_NEG) || (cut_word == COMMA_POS));
            if (v1_q) begin
                out_word <= cut_word;
            end
        end
    end

    // cycles since reset, for the latency check only
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 2)));

    a_r3_det_locked: assert property (@(posedge clk) disable iff (!rst_n)
        comma_det |-> aligned);

    a_r5_lock_on_comma: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> comma_det);

endmodule

// File: tb/word_aligner_test.sv
module word_aligner_test;

    localparam logic [9:0] KN   = 10'b0011111010;
    localparam logic [9:0] KP   = 10'b1100000101;
    localparam logic [9:0] DA   = 10'b1010101010;
    localparam logic [9:0] DB   = 10'b0101010101;
    localparam logic [9:0] PADV = 10'b1010101010;

    logic       clk = 1'b0;
    logic       rst_n, in_valid, realign_en, rehunt;
    logic [9:0] in_word, out_word;
    logic       out_valid, comma_det, aligned;

    always #4 clk = ~clk;

    word_aligner uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_word    (in_word),
        .in_valid   (in_valid),
        .realign_en (realign_en),
        .rehunt     (rehunt),
        .out_word   (out_word),
        .out_valid  (out_valid),
        .comma_det  (comma_det),
        .aligned    (aligned)
    );

    typedef struct {
        logic [9:0] w;
        logic       det;
        logic       al;
        int         code;
    } exp_t;

    exp_t       sbq[$];
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;
    logic [9:0] mprev  = '0;
    bit         mlock  = 0;
    bit         mrealign = 0;
    int         moff   = 0;
    logic [9:0] acc    = '0;
    int         acnt   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] cut(input logic [19:0] win, input int k);
        return win[19-k -: 10];
    endfunction

    function automatic bit is_k(input logic [9:0] v);
        return (v == KN) || (v == KP);
    endfunction

    function automatic string tag_of(input int code);
        case (code)
            4:       return "R4";
            5:       return "R5";
            6:       return "R6";
            7:       return "R7";
            10:      return "R10";
            default: return "R3";
        endcase
    endfunction

    // driver: one valid word, expectation pushed to the scoreboard
    task automatic send(input logic [9:0] w, input bit gapped);
        logic [19:0] win;
        int          hk;
        exp_t        e;
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        win   = {mprev, w};
        mprev = w;
        hk    = -1;
        for (int k = 9; k >= 0; k--) if (is_k(cut(win, k))) hk = k;
        e.code = mlock ? (gapped ? 10 : 3) : 4;
        if (hk >= 0) begin
            if (!mlock) begin
                mlock  = 1;
                moff   = hk;
                e.code = 5;
            end else if (mrealign) begin
                if (hk != moff) e.code = 7;
                moff = hk;
            end else if (hk != moff) begin
                e.code = 6;
            end
        end
        e.w   = cut(win, moff);
        e.det = is_k(e.w);
        e.al  = mlock;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic bits(input logic [9:0] v, input int n, input int gap);
        for (int i = n - 1; i >= 0; i--) begin
            acc = {acc[8:0], v[i]};
            acnt++;
            if (acnt == 10) begin
                send(acc, gap > 0);
                acnt = 0;
                if (gap > 0) idle(gap);
            end
        end
    endtask

    // pad so that the next symbol starts c bits into a word (offset c)
    task automatic place(input int c, input int gap);
        bits(PADV, (c - acnt + 10) % 10, gap);
    endtask

    task automatic sym(input logic [9:0] v, input int gap);
        bits(v, 10, gap);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!done && rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                chk(0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(out_word == e.w, tag_of(e.code), "out_word", out_word, e.w);
                chk(comma_det == e.det, tag_of(e.code), "comma_det", comma_det, e.det);
                chk(aligned == e.al, e.al ? "R8" : "R4", "aligned", aligned, e.al);
            end
        end
    end

    task automatic summary;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            summary();
        end
    end

    initial begin
        rst_n      = 1'b0;
        in_valid   = 1'b1;
        in_word    = 10'h3FF;
        realign_en = 1'b0;
        rehunt     = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
        chk(comma_det == 0, "R1", "comma_det", comma_det, 0);
        chk(aligned == 0,   "R1", "aligned", aligned, 0);
        chk(out_word == 0,  "R1", "out_word", out_word, 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // R2: two-cycle latency, R4: output is previous word while hunting
        send(DA, 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 0, "R2", "out_valid one cycle after", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1, "R2", "out_valid two cycles after", out_valid, 1);
        idle(3);

        // R5 / R3: hunt and lock at offset 3
        place(3, 0);
        sym(DA, 0); sym(DB, 0); sym(KN, 0); sym(DA, 0); sym(DA, 0);
        sym(KP, 0); sym(DA, 0); sym(DB, 0);
        idle(4);
        chk(aligned == 1, "R5", "aligned after first comma", aligned, 1);

        // R6: comma at another offset is ignored while realign is off
        place(7, 0);
        sym(KN, 0); sym(DA, 0); sym(DA, 0);
        idle(4);
        chk(aligned == 1, "R8", "aligned held while idle", aligned, 1);

        // R7: retrain to a new offset with realign enabled
        realign_en = 1'b1;
        mrealign   = 1;
        place(7, 0);
        sym(KP, 0); sym(DA, 0); sym(DB, 0);
        place(9, 0);
        sym(KN, 0); sym(DA, 0); sym(DA, 0);
        idle(4);

        // R9: rehunt drops alignment
        @(negedge clk);
        rehunt = 1'b1;
        @(negedge clk);
        rehunt = 1'b0;
        mlock  = 0;
        chk(aligned == 0, "R9", "aligned after rehunt", aligned, 0);
        idle(3);
        chk(aligned == 0, "R9", "aligned stays low in hunt", aligned, 0);

        // R10: gapped words, relock at offset 0
        realign_en = 1'b0;
        mrealign   = 0;
        place(0, 2);
        sym(DA, 2); sym(KP, 3); sym(DB, 1); sym(DA, 2); sym(DA, 1);
        idle(4);
        chk(aligned == 1, "R10", "relocked across gaps", aligned, 1);

        // offset 9 with realign enabled, back to back
        realign_en = 1'b1;
        mrealign   = 1;
        place(9, 0);
        sym(KN, 0); sym(DB, 0); sym(DA, 0);
        place(0, 0);
        sym(KP, 0); sym(DA, 0); sym(DA, 0);
        idle(6);

        chk(sbq.size() == 0, "R2", "scoreboard drained", sbq.size(), 0);
        summary();
    end

endmodule